// File: doc/BRIEF.md
# Bridge Delayed-Write Retry Controller

This block is the master-side sequencer of a bus-to-bus bridge. It takes one queued write at a time and issues it to the target bus. It then decides what to do with the termination the target returns. A write arrives with a type and a burst length. The type is either delayed, where the originating initiator is waiting for an outcome, or posted, where the initiator has already been released.

For a delayed write, every target retry is passed back to the initiator and the write is issued again. A completion, a disconnect or either kind of abort ends the write with a status code. A configurable limit on retried attempts stops an endless retry loop. When that limit runs out, the controller raises a system-error strobe, but only when two separate control bits allow it.

For a posted write, nothing is reported back. Retries are repeated without limit, and any other termination simply ends the write. Each write ends with a one-cycle done pulse as the controller goes idle again.

Top module: `bridge_write_retry`

## Requirements
- R1: After reset `reqReady` is 1 and every strobe output is 0. A request is accepted only in a cycle where both `reqValid` and `reqReady` are 1. The type, burst length and `limitSel` are captured at that moment. A request presented while the controller is busy has no effect on the write in progress.
- R2: Each attempt on the target bus is marked by a one-cycle `issueStrobe`. The first attempt of a write appears in the cycle after it is accepted.
- R3: On a delayed write, termination code 1 (retry) produces a one-cycle `initStatusValid` with `initStatus` = 1 (retry), and the write is issued again. This does not apply to the attempt that reaches the limit (see R7).
- R4: On a delayed write, termination code 0 (normal) or 2 (disconnect) ends the write. The initiator receives status 2 (disconnect) when the captured burst length is greater than 1, and status 0 (complete) otherwise.
- R5: On a delayed write, termination code 3 (target abort) ends the write with status 3. In that same cycle, `rxTaSet` and `sigTaSet` each pulse once.
- R6: On a delayed write, termination code 4 (master abort) ends the write with status 4 and no system error. Codes 5 to 7 are treated as code 4.
- R7: The limit on retried attempts is 2^LIMIT_LO_LOG2 when `limitSel` was 0 at acceptance and 2^LIMIT_HI_LOG2 when it was 1. When the attempt that reaches the limit is retried, no status is returned for it. The write then ends through the error state instead.
- R8: On limit exhaustion, `serrStrobe` pulses for one cycle only if `serrEnable` is 1 and `nonDeliveryDis` is 0. It never coincides with `initStatusValid`.
- R9: A posted write never drives `initStatusValid`, `rxTaSet`, `sigTaSet` or `serrStrobe`. A retry reissues it with no limit, and every other code ends it.
- R10: The retry count starts from zero for every accepted write, so the retries of earlier writes never shorten the limit of a later one.
- R11: Every accepted write ends with exactly one one-cycle `done` pulse. `reqReady` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A queued write is presented |
| reqPosted | input | 1 | 1 = posted write, 0 = delayed write |
| reqBurst | input | BURST_W | Number of data phases requested |
| limitSel | input | 1 | Retry limit select: 0 = low limit, 1 = high limit |
| reqReady | output | 1 | Controller is idle and accepts a write |
| issueStrobe | output | 1 | One attempt is started on the target bus |
| termValid | input | 1 | Target termination for the current attempt is present |
| termCode | input | 3 | 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| serrEnable | input | 1 | System-error reporting enable |
| nonDeliveryDis | input | 1 | Suppresses the system error for undelivered delayed writes |
| initStatusValid | output | 1 | Status toward the initiator is valid this cycle |
| initStatus | output | 3 | 0 complete, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| rxTaSet | output | 1 | Pulse: set the received-target-abort flag on the target side |
| sigTaSet | output | 1 | Pulse: set the signalled-target-abort flag on the initiator side |
| serrStrobe | output | 1 | System-error strobe on retry-limit exhaustion |
| done | output | 1 | One-cycle pulse as the write finishes |

## Verification
The assertions check several rules on every cycle:
- the system-error strobe is gated by the two control bits and never overlaps a status;
- the two target-abort flag pulses always come together, and only with a target-abort status;
- the issue and done strobes last one cycle;
- an accepted request leads to an issue in the next cycle, and the controller is never ready while an attempt is outstanding.

The bench's scenarios cover what no single-cycle property can show:
- the number of attempts and retry reports up to each of the two limits;
- the mapping from burst length to the returned status;
- posted writes retrying past the limit;
- the counter starting again for each new write;
- a request presented mid-write being ignored.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  localparam logic [2:0] TERM_NORMAL = 3'd0;
  localparam logic [2:0] TERM_RETRY  = 3'd1;
  localparam logic [2:0] TERM_DISC   = 3'd2;
  localparam logic [2:0] TERM_TABORT = 3'd3;
  localparam logic [2:0] TERM_MABORT = 3'd4;

  localparam logic [2:0] STAT_COMPLETE = 3'd0;
  localparam logic [2:0] STAT_RETRY    = 3'd1;
  localparam logic [2:0] STAT_DISC     = 3'd2;
  localparam logic [2:0] STAT_TABORT   = 3'd3;
  localparam logic [2:0] STAT_MABORT   = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_TERM,
    ST_RESPOND,
    ST_ERROR
  } ctrlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request, clear the retry count
    logic capture;  // capture the termination of the current attempt
    logic cntInc;   // count one retried attempt
    logic respond;  // final or intermediate response cycle
    logic fault;    // retry limit exhausted
  } ctlStrobeT;

endpackage

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       termValid,
  input  logic [2:0] termCode,
  input  logic       postedQ,
  input  logic       exhaustNext,
  input  logic       termRetryQ,
  output ctlStrobeT  ctl,
  output logic       reqReady,
  output logic       issueStrobe,
  output logic       done
);

  ctrlStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.respond = (state == ST_RESPOND);
    ctl.fault   = (state == ST_ERROR);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_WAIT_TERM;
      ST_WAIT_TERM: begin
        if (termValid) begin
          ctl.capture = 1'b1;
          if (termCode == TERM_RETRY) begin
            ctl.cntInc = 1'b1;
            if (postedQ)          stateNext = ST_ISSUE;
            else if (exhaustNext) stateNext = ST_ERROR;
            else                  stateNext = ST_RESPOND;
          end else begin
            stateNext = ST_RESPOND;
          end
        end
      end
      ST_RESPOND: stateNext = termRetryQ ? ST_ISSUE : ST_IDLE;
      ST_ERROR:   stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign issueStrobe = (state == ST_ISSUE);
  assign done        = ((state == ST_RESPOND) && !termRetryQ) || (state == ST_ERROR);

endmodule

// File: rtl/bwr_datapath.sv
module bwr_datapath
  import bwr_pkg::*;
#(
  parameter int BURST_W       = 8,
  parameter int LIMIT_LO_LOG2 = 24,
  parameter int LIMIT_HI_LOG2 = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          ctl,
  input  logic               reqPosted,
  input  logic [BURST_W-1:0] reqBurst,
  input  logic               limitSel,
  input  logic [2:0]         termCode,
  input  logic               serrEnable,
  input  logic               nonDeliveryDis,
  output logic               postedQ,
  output logic               exhaustNext,
  output logic               termRetryQ,
  output logic               initStatusValid,
  output logic [2:0]         initStatus,
  output logic               rxTaSet,
  output logic               sigTaSet,
  output logic               serrStrobe
);

  localparam int CNT_W = LIMIT_HI_LOG2 + 1;

  logic             multiQ;
  logic             limSelQ;
  logic [2:0]       termQ;
  logic [2:0]       termNorm;
  logic [CNT_W-1:0] retryCnt;
  logic [CNT_W-1:0] limitVal;
  logic [CNT_W:0]   cntPlusOne;
  logic [2:0]       mappedStatus;

  // undefined codes collapse onto master abort
  assign termNorm = (termCode > TERM_MABORT) ? TERM_MABORT : termCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postedQ  <= 1'b0;
      multiQ   <= 1'b0;
      limSelQ  <= 1'b0;
      termQ    <= TERM_NORMAL;
      retryCnt <= '0;
    end else begin
      if (ctl.load) begin
        postedQ  <= reqPosted;
        multiQ   <= (reqBurst > BURST_W'(1));
        limSelQ  <= limitSel;
        retryCnt <= '0;
      end
      if (ctl.capture) termQ <= termNorm;
      // saturating so unlimited posted retries never wrap
      if (ctl.cntInc && !(&retryCnt)) retryCnt <= retryCnt + 1'b1;
    end
  end

  assign limitVal    = limSelQ ? (CNT_W'(1) << LIMIT_HI_LOG2) : (CNT_W'(1) << LIMIT_LO_LOG2);
  assign cntPlusOne  = {1'b0, retryCnt} + 1'b1;
  assign exhaustNext = (cntPlusOne >= {1'b0, limitVal});
  assign termRetryQ  = (termQ == TERM_RETRY);

  always_comb begin
    case (termQ)
      TERM_RETRY:  mappedStatus = STAT_RETRY;
      TERM_TABORT: mappedStatus = STAT_TABORT;
      TERM_MABORT: mappedStatus = STAT_MABORT;
      default:     mappedStatus = multiQ ? STAT_DISC : STAT_COMPLETE;
    endcase
  end

  assign initStatusValid = ctl.respond && !postedQ;
  assign initStatus      = initStatusValid ? mappedStatus : STAT_COMPLETE;
  assign rxTaSet         = initStatusValid && (termQ == TERM_TABORT);
  assign sigTaSet        = rxTaSet;
  assign serrStrobe      = ctl.fault && serrEnable && !nonDeliveryDis;

endmodule

// File: rtl/bridge_write_retry.sv
module bridge_write_retry
  import bwr_pkg::*;
#(
  parameter int BURST_W       = 8,
  parameter int LIMIT_LO_LOG2 = 24,
  parameter int LIMIT_HI_LOG2 = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqPosted,
  input  logic [BURST_W-1:0] reqBurst,
  input  logic               limitSel,
  output logic               reqReady,
  output logic               issueStrobe,
  input  logic               termValid,
  input  logic [2:0]         termCode,
  input  logic               serrEnable,
  input  logic               nonDeliveryDis,
  output logic               initStatusValid,
  output logic [2:0]         initStatus,
  output logic               rxTaSet,
  output logic               sigTaSet,
  output logic               serrStrobe,
  output logic               done
);

  ctlStrobeT ctl;
  logic      postedQ;
  logic      exhaustNext;
  logic      termRetryQ;

  bwr_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .termValid   (termValid),
    .termCode    (termCode),
    .postedQ     (postedQ),
    .exhaustNext (exhaustNext),
    .termRetryQ  (termRetryQ),
    .ctl         (ctl),
    .reqReady    (reqReady),
    .issueStrobe (issueStrobe),
    .done        (done)
  );

  bwr_datapath #(
    .BURST_W       (BURST_W),
    .LIMIT_LO_LOG2 (LIMIT_LO_LOG2),
    .LIMIT_HI_LOG2 (LIMIT_HI_LOG2)
  ) i_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .ctl             (ctl),
    .reqPosted       (reqPosted),
    .reqBurst        (reqBurst),
    .limitSel        (limitSel),
    .termCode        (termCode),
    .serrEnable      (serrEnable),
    .nonDeliveryDis  (nonDeliveryDis),
    .postedQ         (postedQ),
    .exhaustNext     (exhaustNext),
    .termRetryQ      (termRetryQ),
    .initStatusValid (initStatusValid),
    .initStatus      (initStatus),
    .rxTaSet         (rxTaSet),
    .sigTaSet        (sigTaSet),
    .serrStrobe      (serrStrobe)
  );

endmodule

// File: rtl/bwr_checker.sv
module bwr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       issueStrobe,
  input logic       serrEnable,
  input logic       nonDeliveryDis,
  input logic       initStatusValid,
  input logic [2:0] initStatus,
  input logic       rxTaSet,
  input logic       sigTaSet,
  input logic       serrStrobe,
  input logic       done
);

  // R8
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    serrStrobe |-> (serrEnable && !nonDeliveryDis));

  // R8
  serr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    serrStrobe |-> !initStatusValid);

  // R5
  ta_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTaSet |-> (sigTaSet && initStatusValid && initStatus == 3'd3));

  // R5
  ta_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    sigTaSet |-> rxTaSet);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R2
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueStrobe |=> !issueStrobe);

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> issueStrobe);

  // R1
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueStrobe |-> !reqReady);

endmodule

bind bridge_write_retry bwr_checker i_chk (.*);

// File: tb/test_bridge_write_retry.sv
module test_bridge_write_retry;

  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqPosted = 1'b0;
  logic [BW-1:0] reqBurst = '0;
  logic          limitSel = 1'b0;
  logic          reqReady;
  logic          issueStrobe;
  logic          termValid = 1'b0;
  logic [2:0]    termCode = '0;
  logic          serrEnable = 1'b0;
  logic          nonDeliveryDis = 1'b0;
  logic          initStatusValid;
  logic [2:0]    initStatus;
  logic          rxTaSet;
  logic          sigTaSet;
  logic          serrStrobe;
  logic          done;

  always #2 clk = ~clk;

  bridge_write_retry #(.BURST_W(BW), .LIMIT_LO_LOG2(2), .LIMIT_HI_LOG2(3)) i_bridge_write_retry (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPosted(reqPosted), .reqBurst(reqBurst),
    .limitSel(limitSel), .reqReady(reqReady), .issueStrobe(issueStrobe), .termValid(termValid),
    .termCode(termCode), .serrEnable(serrEnable), .nonDeliveryDis(nonDeliveryDis),
    .initStatusValid(initStatusValid), .initStatus(initStatus), .rxTaSet(rxTaSet),
    .sigTaSet(sigTaSet), .serrStrobe(serrStrobe), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  // monitor counters
  int nIssue, nRetryStat, nFinal, lastFinal, nRxTa, nSigTa, nSerr, nDone;

  always @(negedge clk) begin
    if (issueStrobe) nIssue++;
    if (initStatusValid) begin
      if (initStatus == 3'd1) nRetryStat++;
      else begin nFinal++; lastFinal = int'(initStatus); end
    end
    if (rxTaSet)    nRxTa++;
    if (sigTaSet)   nSigTa++;
    if (serrStrobe) nSerr++;
    if (done)       nDone++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    nIssue = 0; nRetryStat = 0; nFinal = 0; lastFinal = -1;
    nRxTa = 0; nSigTa = 0; nSerr = 0; nDone = 0;
  endtask

  typedef struct packed {
    logic       posted;
    logic [3:0] burst;
    logic [7:0] nRetry;
    logic [2:0] code;
    logic       limSel;
    logic       serrEn;
    logic       dis;
    logic [7:0] expAtt;
    logic [7:0] expRetry;
    logic       expFinV;
    logic [2:0] expFin;
    logic       expTa;
    logic       expSerr;
  } vecT;

  // limits in this bench: low = 4 attempts, high = 8 attempts
  localparam int NVEC = 16;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 4'd1, 8'd0,  3'd0, 1'b0, 1'b1, 1'b0, 8'd1,  8'd0, 1'b1, 3'd0, 1'b0, 1'b0}, // R4 single phase
    '{1'b0, 4'd4, 8'd0,  3'd0, 1'b0, 1'b1, 1'b0, 8'd1,  8'd0, 1'b1, 3'd2, 1'b0, 1'b0}, // R4 burst
    '{1'b0, 4'd1, 8'd2,  3'd2, 1'b0, 1'b1, 1'b0, 8'd3,  8'd2, 1'b1, 3'd0, 1'b0, 1'b0}, // R3 R4
    '{1'b0, 4'd2, 8'd1,  3'd2, 1'b0, 1'b1, 1'b0, 8'd2,  8'd1, 1'b1, 3'd2, 1'b0, 1'b0}, // R4 disconnect burst
    '{1'b0, 4'd3, 8'd3,  3'd3, 1'b0, 1'b1, 1'b0, 8'd4,  8'd3, 1'b1, 3'd3, 1'b1, 1'b0}, // R5 at last legal try
    '{1'b0, 4'd1, 8'd1,  3'd4, 1'b0, 1'b1, 1'b0, 8'd2,  8'd1, 1'b1, 3'd4, 1'b0, 1'b0}, // R6
    '{1'b0, 4'd1, 8'd10, 3'd0, 1'b0, 1'b1, 1'b0, 8'd4,  8'd3, 1'b0, 3'd0, 1'b0, 1'b1}, // R7 R8 low limit
    '{1'b0, 4'd1, 8'd10, 3'd0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd3, 1'b0, 3'd0, 1'b0, 1'b0}, // R8 enable off
    '{1'b0, 4'd1, 8'd10, 3'd0, 1'b0, 1'b1, 1'b1, 8'd4,  8'd3, 1'b0, 3'd0, 1'b0, 1'b0}, // R8 disabled event
    '{1'b0, 4'd1, 8'd10, 3'd0, 1'b1, 1'b1, 1'b0, 8'd8,  8'd7, 1'b0, 3'd0, 1'b0, 1'b1}, // R7 high limit
    '{1'b0, 4'd1, 8'd7,  3'd0, 1'b1, 1'b1, 1'b0, 8'd8,  8'd7, 1'b1, 3'd0, 1'b0, 1'b0}, // R7 last try succeeds
    '{1'b1, 4'd4, 8'd0,  3'd0, 1'b0, 1'b1, 1'b0, 8'd1,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 posted normal
    '{1'b1, 4'd1, 8'd12, 3'd0, 1'b0, 1'b1, 1'b0, 8'd13, 8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 past the limit
    '{1'b1, 4'd1, 8'd2,  3'd3, 1'b0, 1'b1, 1'b0, 8'd3,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 posted abort
    '{1'b0, 4'd1, 8'd0,  3'd6, 1'b0, 1'b1, 1'b0, 8'd1,  8'd0, 1'b1, 3'd4, 1'b0, 1'b0}, // R6 undefined code
    '{1'b0, 4'd1, 8'd3,  3'd0, 1'b0, 1'b1, 1'b0, 8'd4,  8'd3, 1'b1, 3'd0, 1'b0, 1'b0}  // R10 count restarts
  };

  task automatic runVec(input vecT v, input int idx);
    int n = 0;
    int guard = 0;
    bit fin = 0;
    clearMon();
    @(negedge clk);
    reqPosted = v.posted; reqBurst = v.burst; limitSel = v.limSel;
    serrEnable = v.serrEn; nonDeliveryDis = v.dis; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(issueStrobe == 1'b1, $sformatf("R2 first issue vec %0d", idx), int'(issueStrobe), 1);
    while (!fin && guard < 2000) begin
      if (issueStrobe) begin
        @(negedge clk);
        termValid = 1'b1;
        termCode  = (n < int'(v.nRetry)) ? 3'd1 : v.code;
        n++;
        @(negedge clk);
        termValid = 1'b0;
      end else begin
        if (done) fin = 1;
        else @(negedge clk);
      end
      guard++;
    end
    @(negedge clk);
    chk(nIssue == int'(v.expAtt), $sformatf("R7 R9 attempts vec %0d", idx), nIssue, int'(v.expAtt));
    chk(nRetryStat == int'(v.expRetry), $sformatf("R3 retry reports vec %0d", idx), nRetryStat, int'(v.expRetry));
    chk(nFinal == int'(v.expFinV), $sformatf("R4 R6 R9 final reports vec %0d", idx), nFinal, int'(v.expFinV));
    if (v.expFinV)
      chk(lastFinal == int'(v.expFin), $sformatf("R4 R5 R6 final status vec %0d", idx), lastFinal, int'(v.expFin));
    chk(nRxTa == int'(v.expTa) && nSigTa == int'(v.expTa), $sformatf("R5 abort flags vec %0d", idx),
        nRxTa * 10 + nSigTa, int'(v.expTa) * 11);
    chk(nSerr == int'(v.expSerr), $sformatf("R8 serr vec %0d", idx), nSerr, int'(v.expSerr));
    chk(nDone == 1, $sformatf("R11 done count vec %0d", idx), nDone, 1);
    chk(reqReady == 1'b1, $sformatf("R11 ready after done vec %0d", idx), int'(reqReady), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reset ready", int'(reqReady), 1);
    chk({issueStrobe, initStatusValid, rxTaSet, sigTaSet, serrStrobe, done} == 6'b0,
        "R1 reset strobes", int'({issueStrobe, initStatusValid, rxTaSet, sigTaSet, serrStrobe, done}), 0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R1 a request while busy has no effect on the write in flight
    clearMon();
    @(negedge clk);
    reqPosted = 1'b0; reqBurst = 4'd4; limitSel = 1'b0; serrEnable = 1'b1; nonDeliveryDis = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);               // waiting for termination
    reqValid = 1'b1; reqPosted = 1'b1; reqBurst = 4'd1; limitSel = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    termValid = 1'b1; termCode = 3'd0;
    @(negedge clk);
    termValid = 1'b0;
    chk(initStatusValid && initStatus == 3'd2, "R1 busy request ignored status",
        int'(initStatus), 2);
    chk(done == 1'b1, "R11 done in response cycle", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(nIssue == 1 && reqReady == 1'b1, "R1 no extra write started", nIssue, 1);
    chk(nDone == 1, "R11 single done", nDone, 1);

    summary();
    $finish;
  end

endmodule